// File: doc/BRIEF.md
# Branch-on-Bit Decode and Resolve Unit

This unit sits in the decode/execute path of a 64-bit pipelined processor. It spots the four conditional branches that test a single bit of a general register. For such a branch it reports the source register index so the operand can be fetched. From the operand that comes back it resolves the branch in the same cycle: the taken flag and the address control moves to once the delay slot has executed.

The six-bit index of the tested bit is not stored as one field. Its upper bit is one of the opcode bits and its lower five bits sit in the operand field. One opcode bit also chooses whether a set or a clear bit takes the branch. Every accepted branch opens a delay slot for the next accepted instruction, and a one-bit register tracks that slot. A branch that turns up in a slot is not resolved; the unit flags a reserved-instruction exception instead.

The outputs are combinational from the inputs and the slot register. The slot register is the only state and is updated on each accepted instruction.

Top module: `bitbr_unit`

## Requirements
- R1: `hit` is 1 exactly when `in_valid` is 1, `instr[31:30]` is 2'b11 and `instr[27:26]` is 2'b10. This covers primary opcodes 6'b110010, 6'b110110, 6'b111010 and 6'b111110.
- R2: `src_idx` always equals `instr[25:21]`.
- R3: The tested bit is `src_val[p]`, where p = 32*`instr[28]` + `instr[20:16]` (range 0 to 63).
- R4: With `instr[29]`=1 the branch is taken when the tested bit is 1; with `instr[29]`=0 it is taken when the tested bit is 0.
- R5: For a taken branch, `target` = `pc` + 4 + 4*sign-extended `instr[15:0]` (modulo 2^64), so negative offsets branch backwards.
- R6: For a resolved branch that is not taken, `target` = `pc` + 8.
- R7: A registered slot flag is set after an accepted (`in_valid`=1) matching branch that did not trap. Any other accepted instruction clears it, and cycles with `in_valid`=0 leave it unchanged.
- R8: A matching instruction seen while the slot flag is set drives `ri_trap`=1, `taken`=0 and `target`=0, and does not set the slot flag.
- R9: When `hit` is 0, `taken`, `ri_trap` and `target` are all 0.
- R10: Synchronous reset (`rst`=1 at a rising edge) clears the slot flag, so the next branch resolves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| src_val | input | 64 | Value of register `src_idx` |
| hit | output | 1 | Instruction is a branch-on-bit |
| src_idx | output | 5 | Source register index |
| taken | output | 1 | Branch resolved as taken |
| target | output | 64 | Next address after the delay slot (0 when unresolved) |
| ri_trap | output | 1 | Branch found in a delay slot: reserved-instruction exception |

## Verification
The result outputs are due in the same cycle as the instruction, because they are combinational from the inputs and the slot register. The bench drives each instruction just after a rising edge and compares all five outputs with its model at the following falling edge. The slot flag takes effect one accepted instruction later. The model advances its own slot state only at the edge where the design's register would load, so back-to-back branches, bubbles between them and a reset in between are each checked in the cycle the change becomes visible.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  localparam int XLEN  = 64;
  localparam int ILEN  = 32;
  localparam int POS_W = 6;
  localparam int OFF_W = 16;
  localparam int RS_W  = 5;

  typedef struct packed {
    logic             on_set;
    logic [POS_W-1:0] pos;
    logic [RS_W-1:0]  rs;
    logic [OFF_W-1:0] off;
  } bb_fields_t;

  function automatic logic [POS_W-1:0] bit_pos(input logic [ILEN-1:0] iw);
    return {iw[28], iw[20:16]};
  endfunction

  function automatic logic [XLEN-1:0] jump_addr(input logic [XLEN-1:0] pc,
                                               input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
    return pc + XLEN'(4) + (sx << 2);
  endfunction

  function automatic logic [XLEN-1:0] fall_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(8);
  endfunction
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
  import bitbr_pkg::*;
(
  input  logic            valid,
  input  logic [ILEN-1:0] iw,
  output logic            is_bb,
  output bb_fields_t      flds
);
  logic pat_hi, pat_lo;

  assign pat_hi = (iw[31:30] == 2'b11);
  assign pat_lo = (iw[27:26] == 2'b10);
  assign is_bb  = valid & pat_hi & pat_lo;

  always_comb begin
    flds.on_set = iw[29];
    flds.pos    = bit_pos(iw);
    flds.rs     = iw[25:21];
    flds.off    = iw[15:0];
  end
endmodule

// File: rtl/bitbr_test.sv
module bitbr_test
  import bitbr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0]     opnd,
  input  logic [POS_W-1:0] pos,
  input  logic             on_set,
  output logic             cond
);
  logic sel_bit;

  generate
    if (W == (1 << POS_W)) begin : g_full
      assign sel_bit = opnd[pos];
    end else begin : g_part
      assign sel_bit = (int'(pos) < W) ? opnd[pos] : 1'b0;
    end
  endgenerate

  assign cond = on_set ? sel_bit : ~sel_bit;
endmodule

// File: rtl/bitbr_target.sv
module bitbr_target
  import bitbr_pkg::*;
(
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             go,
  input  logic             resolve,
  output logic [XLEN-1:0]  nxt
);
  logic [XLEN-1:0] jmp, seq;

  assign jmp = jump_addr(pc, off);
  assign seq = fall_addr(pc);
  assign nxt = !resolve ? '0 : (go ? jmp : seq);
endmodule

// File: rtl/bitbr_slot.sv
module bitbr_slot (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic arm,
  output logic slot_q
);
  always_ff @(posedge clk) begin
    if (rst)         slot_q <= 1'b0;
    else if (accept) slot_q <= arm;
  end

  // R7
  slot_arm_chk: assert property (@(posedge clk) disable iff (rst)
    accept && arm |=> slot_q);
  // R7
  slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !arm |=> !slot_q);
  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(slot_q));
  // R10
  reset_clr_chk: assert property (@(posedge clk)
    rst |=> !slot_q);
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [63:0]     pc,
  input  logic [63:0]     src_val,
  output logic            hit,
  output logic [4:0]      src_idx,
  output logic            taken,
  output logic [63:0]     target,
  output logic            ri_trap
);
  bb_fields_t flds;
  logic       is_bb;
  logic       cond;
  logic       in_slot;
  logic       resolve;
  logic       arm_slot;

  bitbr_decode u_dec (
    .valid (in_valid),
    .iw    (instr),
    .is_bb (is_bb),
    .flds  (flds)
  );

  bitbr_test #(.W(XLEN)) u_tst (
    .opnd   (src_val),
    .pos    (flds.pos),
    .on_set (flds.on_set),
    .cond   (cond)
  );

  assign resolve  = is_bb & ~in_slot;
  assign arm_slot = resolve;

  bitbr_target u_tgt (
    .pc      (pc),
    .off     (flds.off),
    .go      (cond),
    .resolve (resolve),
    .nxt     (target)
  );

  bitbr_slot u_slot (
    .clk    (clk),
    .rst    (rst),
    .accept (in_valid),
    .arm    (arm_slot),
    .slot_q (in_slot)
  );

  assign hit     = is_bb;
  assign src_idx = flds.rs;
  assign taken   = resolve & cond;
  assign ri_trap = is_bb & in_slot;

  // R1
  hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> in_valid);
  // R8
  trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ri_trap |-> !taken && target == '0);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken, ri_trap}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> !taken && !ri_trap && target == '0);
  // R6
  fall_addr_chk: assert property (@(posedge clk) disable iff (rst)
    hit && !ri_trap && !taken |-> target == pc + 64'd8);
endmodule

// File: tb/bitbr_unit_bench.sv
module bitbr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] pc = '0;
  logic [63:0] src_val = '0;
  logic        hit, taken, ri_trap;
  logic [4:0]  src_idx;
  logic [63:0] target;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_slot = 0;
  string trap_tag = "R8";

  always #2 clk = ~clk;

  bitbr_unit u_bitbr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
    .src_val(src_val), .hit(hit), .src_idx(src_idx), .taken(taken),
    .target(target), .ri_trap(ri_trap)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit pol, bit hi, int rs, int lo, int off);
    logic [31:0] w;
    w = 32'hC800_0000;
    w[29] = pol; w[28] = hi;
    w[25:21] = rs[4:0]; w[20:16] = lo[4:0]; w[15:0] = off[15:0];
    return w;
  endfunction

  task automatic step(bit v, logic [31:0] iw, logic [63:0] p, logic [63:0] s);
    bit e_hit, e_take, e_trap, bitv;
    int pos;
    longint off;
    logic [63:0] e_tgt;
    string ttag;
    @(posedge clk); #1;
    in_valid = v; instr = iw; pc = p; src_val = s;
    @(negedge clk);
    e_hit = v && iw[31:30] == 2'b11 && iw[27:26] == 2'b10;
    pos = (iw[28] ? 32 : 0) + int'(iw[20:16]);
    bitv = s[pos];
    e_trap = e_hit && m_slot;
    e_take = e_hit && !m_slot && (iw[29] ? bitv : !bitv);
    off = longint'($signed(iw[15:0])) * 4;
    if (!e_hit || e_trap) e_tgt = 0;
    else if (e_take) e_tgt = p + 64'd4 + off;
    else e_tgt = p + 64'd8;
    chk(e_hit ? "R1" : "R9", "hit", 64'(hit), 64'(e_hit));
    chk("R2", "src_idx", 64'(src_idx), 64'(iw[25:21]));
    ttag = !e_hit ? "R9" : (e_trap ? "R8" : (iw[28] ? "R3" : "R4"));
    chk(ttag, "taken", 64'(taken), 64'(e_take));
    ttag = !e_hit ? "R9" : (e_trap ? "R8" : (e_take ? "R5" : "R6"));
    chk(ttag, "target", target, e_tgt);
    chk(trap_tag, "ri_trap", 64'(ri_trap), 64'(e_trap));
    if (rst) m_slot = 0;
    else if (v) m_slot = e_hit && !e_trap;
  endtask

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    trap_tag = "R10";
    step(0, '0, 64'h0, 64'h0);
    step(0, '0, 64'h0, 64'h0);
    rst = 1'b0;
    step(1, mk(1, 0, 3, 5, 16), 64'h1000, 64'h20);
    trap_tag = "R8";
    // R9 non-matching words
    step(1, 32'h8C00_0000, 64'h2000, 64'h0);
    step(1, 32'hCC00_0000, 64'h2000, 64'h0);
    step(1, 32'h4800_0000, 64'h2000, 64'h0);
    // R1 four opcodes, R4 polarity, each separated by a non-branch
    for (int k = 0; k < 4; k++) begin
      step(1, mk(k[1], k[0], k, 7, 3), 64'h4000, 64'h80);
      step(1, 32'h0, 64'h4004, 64'h0);
      step(1, mk(k[1], k[0], k, 7, 3), 64'h4000, 64'h0);
      step(1, 32'h0, 64'h4004, 64'h0);
    end
    // R3 boundary positions 0, 31, 32, 63
    step(1, mk(1, 0, 1, 0, 1), 64'h10, 64'h1); step(1, 0, 0, 0);
    step(1, mk(1, 0, 1, 31, 1), 64'h10, 64'h8000_0000); step(1, 0, 0, 0);
    step(1, mk(1, 1, 1, 0, 1), 64'h10, 64'h1_0000_0000); step(1, 0, 0, 0);
    step(1, mk(1, 1, 1, 31, 1), 64'h10, 64'h8000_0000_0000_0000); step(1, 0, 0, 0);
    step(1, mk(1, 1, 1, 31, 1), 64'h10, 64'h7FFF_FFFF_FFFF_FFFF); step(1, 0, 0, 0);
    // R5 offset extremes and wrap
    step(1, mk(0, 0, 2, 4, 16'h8000), 64'h0010_0000, 64'h0); step(1, 0, 0, 0);
    step(1, mk(0, 0, 2, 4, 16'h7FFF), 64'h0010_0000, 64'h0); step(1, 0, 0, 0);
    step(1, mk(0, 0, 2, 4, 16'hFFFF), 64'h0, 64'h0); step(1, 0, 0, 0);
    // R7 / R8 back-to-back: second traps, third resolves again
    trap_tag = "R7";
    step(1, mk(1, 0, 4, 2, 8), 64'h500, 64'h4);
    step(1, mk(1, 0, 4, 2, 8), 64'h504, 64'h4);
    step(1, mk(0, 0, 4, 2, 8), 64'h508, 64'h0);
    step(1, 32'h0, 64'h50C, 64'h0);
    // R7 bubbles hold the slot
    step(1, mk(0, 1, 6, 9, 2), 64'h600, 64'h0);
    step(0, mk(0, 1, 6, 9, 2), 64'h604, 64'h0);
    step(0, 32'h0, 64'h604, 64'h0);
    step(1, mk(0, 1, 6, 9, 2), 64'h604, 64'h0);
    step(1, 32'h0, 64'h608, 64'h0);
    // R10 reset clears an armed slot
    trap_tag = "R10";
    step(1, mk(1, 0, 1, 1, 1), 64'h700, 64'h2);
    rst = 1'b1;
    step(0, 32'h0, 64'h704, 64'h0);
    rst = 1'b0;
    step(1, mk(1, 0, 1, 1, 1), 64'h704, 64'h2);
    step(1, 32'h0, 64'h708, 64'h0);
    trap_tag = "R8";
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom % 3 != 0) begin w[31:30] = 2'b11; w[27:26] = 2'b10; end
      step(($urandom % 5) != 0, w, {$urandom, $urandom}, {$urandom, $urandom});
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule